// File: doc/BRIEF.md
# Dual-Master I2C Channel Selector

This block decides which of two upstream I2C masters is connected to a shared downstream bus. Each master issues an already-decoded select pulse, and either master may take the bus at any moment. This is how a surviving master takes over when its partner has failed or been pulled from the system. The block drives a one-hot-or-zero grant vector that the surrounding pass-gate logic uses to join one upstream bus to the downstream side. It also drives one active-low interrupt line toward each master.

A switch can go straight through, or it can first wait for an external recovery sequencer. In that case the block pulses a start strobe, keeps both upstream channels disconnected, and grants the new master only when the sequencer reports done. When recovery is off, a bus-busy monitor input tells the block whether the downstream bus was in mid-transfer at the moment of a switch. A static start-up option picks channel 0 or no channel after reset.

Each master's interrupt line combines four sources: it lost the grant, downstream interrupt forwarding, recovery completed, and switched while the bus was busy. Each source has its own mask bit. The latched sources stay asserted until the master clears them with a pulse. There is no data stream in this block, so every pin is a plain control or status signal with no valid/ready back-pressure.

Top module: `i2c_dual_master_sel`

## Requirements
- R1: `grant` is never `2'b11`. Bit 0 connects master 0 and bit 1 connects master 1.
- R2: After reset, `grant` is `2'b01` when `boot_ch0` is 1 and `2'b00` when it is 0. Both `int_n` bits are 1 (idle) and `rec_start` is 0.
- R3: With `rec_en` low, a select pulse from a master that does not hold the grant moves `grant` to that master at the next clock edge. A pulse from the current holder changes nothing and raises no interrupt.
- R4: When both `sel_req` bits pulse in the same cycle, the master not holding the grant wins. If neither holds it, master 0 wins.
- R5: When the grant leaves a master, that master's `int_n` bit goes low after the same edge. Mask bit 0 (`lost`) of that master suppresses this.
- R6: While `int_in_n` is low, each `int_n` bit is low in the same cycle unless that master's mask bit 1 (`forward`) is set.
- R7: With `rec_en` high, a switching pulse clears `grant` to `2'b00` and makes `rec_start` high for exactly the following cycle. The grant stays `2'b00` until `rec_done`, and the edge that samples `rec_done` grants the new master. That master's `int_n` goes low unless its mask bit 2 (`recovered`) is set.
- R8: With `rec_en` low, a switch taken while `bus_busy` is high drives the new holder's `int_n` low, unless its mask bit 3 (`busy`) is set.
- R9: A latched interrupt (lost, recovered, busy) remains until a pulse on that master's `int_clr` bit. If a set and a clear meet in the same cycle, the set wins.
- R10: `rec_done` outside a recovery wait has no effect on `grant` or `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_ch0 | input | 1 | Static start-up option: 1 grants master 0 after reset |
| sel_req | input | 2 | Decoded select pulse per master (bit i = master i) |
| rec_en | input | 1 | Route switches through the recovery sequencer |
| rec_start | output | 1 | One-cycle request to the recovery sequencer |
| rec_done | input | 1 | Recovery sequencer completion pulse |
| bus_busy | input | 1 | Downstream bus not idle, from the bus monitor |
| int_in_n | input | 1 | Downstream interrupt, active low |
| mask_m0 | input | 4 | Master 0 source masks: bit0 lost, bit1 forward, bit2 recovered, bit3 busy; 1 = masked |
| mask_m1 | input | 4 | Master 1 source masks, same layout |
| int_clr | input | 2 | Clear pulse for each master's latched interrupts |
| grant | output | 2 | One-hot-or-zero channel connection |
| int_n | output | 2 | Active-low interrupt toward each master |

## Verification
The bench goes after simultaneous requests in both ownership states. A design that used fixed priority would hand the bus back to the holder instead of letting the challenger take over. It checks that a request from the current holder raises no lost interrupt, which would catch a design that treats every pulse as a switch. During a recovery wait it confirms that both channels stay open, that the strobe lasts one cycle, and that a stray done pulse outside the wait leaves the grant alone. It also drives a clear and a new lost event into the same cycle, where a design giving clear priority would drop the interrupt.

// File: rtl/i2cms_pkg.sv
package i2cms_pkg;
  localparam int NCH   = 2;
  localparam int NSRC  = 4;
  localparam int SRC_LOST = 0;
  localparam int SRC_FWD  = 1;
  localparam int SRC_REC  = 2;
  localparam int SRC_BUSY = 3;

  typedef enum logic {ST_LINK = 1'b0, ST_RECOV = 1'b1} sel_st_e;

  function automatic logic [NCH-1:0] ch_onehot(input logic idx);
    ch_onehot = idx ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/sel_prio.sv
module sel_prio
  import i2cms_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] hold,
  output logic           win,
  output logic           valid
);
  always_comb begin
    if (req[0] && req[1]) win = hold[0];
    else                  win = req[1];
    valid = (|req) && !hold[win];
  end
endmodule

// File: rtl/sel_core.sv
module sel_core
  import i2cms_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boot_ch0,
  input  logic [NCH-1:0] sel_req,
  input  logic           rec_en,
  input  logic           rec_done,
  input  logic           bus_busy,
  output logic [NCH-1:0] grant,
  output logic           rec_start,
  output logic [NCH-1:0] lost_evt,
  output logic [NCH-1:0] rec_evt,
  output logic [NCH-1:0] busy_evt
);
  sel_st_e        st_q, st_d;
  logic [NCH-1:0] grant_q, grant_d, hold;
  logic           tgt_q, tgt_d, start_d, start_q;
  logic           win, valid, fin_ch;

  assign hold = (st_q == ST_RECOV) ? ch_onehot(tgt_q) : grant_q;

  sel_prio u_prio (.req(sel_req), .hold(hold), .win(win), .valid(valid));

  always_comb begin
    st_d     = st_q;
    grant_d  = grant_q;
    tgt_d    = tgt_q;
    start_d  = 1'b0;
    lost_evt = '0;
    rec_evt  = '0;
    busy_evt = '0;
    fin_ch   = valid ? win : tgt_q;
    if (st_q == ST_LINK) begin
      if (valid) begin
        lost_evt = grant_q;
        if (rec_en) begin
          st_d    = ST_RECOV;
          tgt_d   = win;
          grant_d = '0;
          start_d = 1'b1;
        end else begin
          grant_d = ch_onehot(win);
          if (bus_busy) busy_evt = ch_onehot(win);
        end
      end
    end else begin
      if (rec_done) begin
        st_d    = ST_LINK;
        grant_d = ch_onehot(fin_ch);
        rec_evt = ch_onehot(fin_ch);
      end else if (valid) begin
        tgt_d = win;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_LINK;
      grant_q <= boot_ch0 ? 2'b01 : 2'b00;
      tgt_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      grant_q <= grant_d;
      tgt_q   <= tgt_d;
      start_q <= start_d;
    end
  end

  assign grant     = grant_q;
  assign rec_start = start_q;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q)); // R1
  AST_RECOV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOV) |-> (grant_q == '0)); // R7
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R7
  AST_HOLDER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINK && (sel_req & ~grant_q) == '0) |=> $stable(grant_q)); // R3
  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LINK && rec_done && sel_req == '0) |=> $stable(grant_q)); // R10
endmodule

// File: rtl/irq_ch.sv
module irq_ch
  import i2cms_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] mask,
  input  logic            lost_evt,
  input  logic            rec_evt,
  input  logic            busy_evt,
  input  logic            int_in_n,
  input  logic            clr,
  output logic            int_n
);
  logic [NSRC-1:0] flag_q, set_v;

  always_comb begin
    set_v           = '0;
    set_v[SRC_LOST] = lost_evt;
    set_v[SRC_REC]  = rec_evt;
    set_v[SRC_BUSY] = busy_evt;
    set_v           = set_v & ~mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= set_v | (clr ? '0 : flag_q);
  end

  assign int_n = !((|flag_q) || (!int_in_n && !mask[SRC_FWD]));

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[s] && mask[s]) |=> !flag_q[s]); // R5 R7 R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[s] && !clr) |=> flag_q[s]); // R9
  end
endmodule

// File: rtl/i2c_dual_master_sel.sv
module i2c_dual_master_sel
  import i2cms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_ch0,
  input  logic [1:0] sel_req,
  input  logic       rec_en,
  output logic       rec_start,
  input  logic       rec_done,
  input  logic       bus_busy,
  input  logic       int_in_n,
  input  logic [3:0] mask_m0,
  input  logic [3:0] mask_m1,
  input  logic [1:0] int_clr,
  output logic [1:0] grant,
  output logic [1:0] int_n
);
  logic [NCH-1:0]            lost_evt, rec_evt, busy_evt;
  logic [NCH-1:0][NSRC-1:0]  mask_all;

  assign mask_all = {mask_m1, mask_m0};

  sel_core u_core (
    .clk(clk), .rst_n(rst_n), .boot_ch0(boot_ch0), .sel_req(sel_req),
    .rec_en(rec_en), .rec_done(rec_done), .bus_busy(bus_busy),
    .grant(grant), .rec_start(rec_start),
    .lost_evt(lost_evt), .rec_evt(rec_evt), .busy_evt(busy_evt)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    irq_ch u_irq (
      .clk(clk), .rst_n(rst_n), .mask(mask_all[c]),
      .lost_evt(lost_evt[c]), .rec_evt(rec_evt[c]), .busy_evt(busy_evt[c]),
      .int_in_n(int_in_n), .clr(int_clr[c]), .int_n(int_n[c])
    );
  end

  AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant != 2'b11); // R1
endmodule

// File: tb/sim_i2c_dual_master_sel.sv
module sim_i2c_dual_master_sel;
  logic clk = 1'b0, rst_n, boot_ch0, rec_en, rec_done, bus_busy, int_in_n, rec_start;
  logic [1:0] sel_req, int_clr, grant, int_n;
  logic [3:0] mask_m0, mask_m1;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  i2c_dual_master_sel u0 (
    .clk(clk), .rst_n(rst_n), .boot_ch0(boot_ch0), .sel_req(sel_req),
    .rec_en(rec_en), .rec_start(rec_start), .rec_done(rec_done),
    .bus_busy(bus_busy), .int_in_n(int_in_n), .mask_m0(mask_m0),
    .mask_m1(mask_m1), .int_clr(int_clr), .grant(grant), .int_n(int_n)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst_n = 0; boot_ch0 = boot; rec_en = 0; rec_done = 0; bus_busy = 0;
    int_in_n = 1; mask_m0 = 0; mask_m1 = 0; int_clr = 0; sel_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_req(input logic [1:0] v);
    @(negedge clk) sel_req = v;
    @(negedge clk) sel_req = 0;
  endtask

  task automatic pulse_clr(input logic [1:0] v);
    @(negedge clk) int_clr = v;
    @(negedge clk) int_clr = 0;
  endtask

  task automatic t_reset;
    do_reset(1); #1;
    chk("R2 grant boot ch0", grant, 2'b01);
    chk("R2 int idle", int_n, 2'b11);
    chk("R2 rec_start low", {1'b0, rec_start}, 2'b00);
    do_reset(0); #1;
    chk("R2 grant boot none", grant, 2'b00);
  endtask

  task automatic t_switch;
    do_reset(1);
    pulse_req(2'b10);
    chk("R3 switch to m1", grant, 2'b10);
    chk("R5 m0 lost int", int_n, 2'b10);
    pulse_clr(2'b01);
    chk("R9 clear m0", int_n, 2'b11);
    pulse_req(2'b10);
    chk("R3 holder req grant", grant, 2'b10);
    chk("R3 holder req no int", int_n, 2'b11);
  endtask

  task automatic t_simul;
    do_reset(0);
    pulse_req(2'b11);
    chk("R4 none held ch0 wins", grant, 2'b01);
    pulse_req(2'b11);
    chk("R4 non-holder m1 wins", grant, 2'b10);
    pulse_req(2'b11);
    chk("R4 non-holder m0 wins", grant, 2'b01);
    chk("R1 never both", {1'b0, grant == 2'b11}, 2'b00);
  endtask

  task automatic t_mask_lost;
    do_reset(1);
    mask_m0 = 4'b0001;
    pulse_req(2'b10);
    chk("R5 masked lost", int_n, 2'b11);
  endtask

  task automatic t_forward;
    do_reset(1);
    mask_m1 = 4'b0010;
    @(negedge clk) int_in_n = 0; #1;
    chk("R6 forward m0 only", int_n, 2'b10);
    mask_m1 = 0; #1;
    chk("R6 forward both", int_n, 2'b00);
    int_in_n = 1; #1;
    chk("R6 forward release", int_n, 2'b11);
  endtask

  task automatic t_recovery(input logic mask_rec);
    do_reset(1);
    rec_en = 1;
    mask_m1 = {1'b0, mask_rec, 2'b00};
    pulse_req(2'b10);
    chk("R7 grant open", grant, 2'b00);
    chk("R7 start high", {1'b0, rec_start}, 2'b01);
    chk("R5 lost at recov", int_n, 2'b10);
    @(negedge clk);
    chk("R7 start one cycle", {1'b0, rec_start}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R7 still open", grant, 2'b00);
    @(negedge clk) rec_done = 1;
    @(negedge clk) rec_done = 0;
    chk("R7 granted after done", grant, 2'b10);
    chk("R7 rec int", int_n, mask_rec ? 2'b10 : 2'b00);
  endtask

  task automatic t_busy(input logic mask_busy);
    do_reset(1);
    bus_busy = 1;
    mask_m1 = {mask_busy, 3'b000};
    pulse_req(2'b10);
    chk("R8 grant", grant, 2'b10);
    chk("R8 busy int", int_n, mask_busy ? 2'b10 : 2'b00);
    repeat (4) @(negedge clk);
    chk("R9 stays asserted", int_n, mask_busy ? 2'b10 : 2'b00);
  endtask

  task automatic t_set_wins;
    do_reset(1);
    pulse_req(2'b10);
    pulse_clr(2'b01);
    @(negedge clk) begin sel_req = 2'b01; int_clr = 2'b10; end
    @(negedge clk) begin sel_req = 2'b00; int_clr = 2'b00; end
    chk("R9 set beats clear", int_n, 2'b01);
    chk("R3 back to m0", grant, 2'b01);
  endtask

  task automatic t_done_ignored;
    do_reset(1);
    rec_en = 1;
    @(negedge clk) rec_done = 1;
    @(negedge clk) rec_done = 0;
    chk("R10 grant unchanged", grant, 2'b01);
    chk("R10 no int", int_n, 2'b11);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_switch();
    t_simul();
    t_mask_lost();
    t_forward();
    t_recovery(0);
    t_recovery(1);
    t_busy(0);
    t_busy(1);
    t_set_wins();
    t_done_ignored();
    finish_run();
  end
endmodule